// File: doc/BRIEF.md
# Dual-Axis Byte Bus Register Front End

This block is the 8-bit host bus side of a two-axis position counting unit. A processor addresses one of two axes (X or Y), and within that axis either a data channel or a control channel. Writes on the data channel fill a multi-byte preset latch one byte at a time. Reads on the data channel drain an externally supplied output latch one byte at a time. A hidden per-axis byte pointer chooses which byte is moved, starting with the least significant byte. The pointer advances by itself after each transfer and returns to zero after the last byte.

Control writes use the top three data bits. Bits 6:5 pick one of four 5-bit registers: command, mode, I/O setup or index setup. Bit 7 sends the write to both axes at once. A command write is also passed on as a one-cycle strobe, so the counting logic next to this block can act on it. Bit 0 of a command clears the byte pointer, and that is handled here. Control reads return the flag byte of the selected axis. The control registers cannot be read back.

The bus strobes are asynchronous to the block clock. They pass through a synchronizer chain, and an edge detector turns each strobe into exactly one internal access.

Top module: `dual_axis_host_port`

## Requirements
- R1: After reset, all preset bytes are 0, all four control registers of both axes are 0, both byte pointers are 0, `cmd_stb_o` is 0 and `data_oe` is 0.
- R2: A data write (cd_i=0) to the axis named by axis_i (0=X, 1=Y) stores data_i into the byte of that axis's preset latch at the pointer (byte 0 = bits 7:0). It then advances that axis's pointer by one.
- R3: After the last byte (index BYTES-1, the third byte by default), a data transfer sets the pointer back to byte 0.
- R4: A data read (cd_i=0) returns on data_o the byte of the selected axis's output latch at its pointer (least significant byte first). It then advances that pointer by one.
- R5: A control write (cd_i=1) picks a register by data bits 6:5: 00 = command, 01 = mode, 10 = I/O setup, 11 = index setup. It stores only data bits 4:0 into that register of the axis named by axis_i.
- R6: A control write with data bit 7 set updates the chosen register in both axes, whatever axis_i is.
- R7: A command write with data bit 0 set clears the byte pointer of every axis it targets. A command write with bit 0 clear leaves the pointer unchanged.
- R8: Each command write raises `cmd_stb_o` of every targeted axis for exactly one clock cycle.
- R9: A control read returns the selected axis's flag byte and does not move any byte pointer.
- R10: Strobes given while cs_n is high change no register, no pointer and no output, and `data_oe` stays low.
- R11: Each low pulse of wr_n or rd_n causes exactly one internal access, however many clock cycles it lasts. A write takes effect on the rising (trailing) edge of wr_n.
- R12: `data_oe` goes high only after the falling edge of a read strobe with cs_n low. It stays high while that read lasts and goes low once rd_n or cs_n returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| cd_i | input | 1 | Channel select: 0 data, 1 control |
| axis_i | input | 1 | Axis select: 0 X, 1 Y |
| data_i | input | 8 | Write data from host |
| data_o | output | 8 | Registered read data |
| data_oe | output | 1 | Registered read-data drive enable |
| out_latch_i | input | 2*BYTES*8 | Output latches, Y in upper half |
| flags_i | input | 16 | Flag bytes, Y in upper byte |
| preset_o | output | 2*BYTES*8 | Preset latches, Y in upper half |
| cmd_o | output | 2*CW | Last command value per axis |
| cmd_stb_o | output | 2 | One-cycle command strobe per axis |
| cmr_o | output | 2*CW | Mode register per axis |
| ior_o | output | 2*CW | I/O setup register per axis |
| idr_o | output | 2*CW | Index setup register per axis |

## Verification
The bench builds the block with three preset bytes and five-bit control registers, so the pointer wrap after the third byte can be observed at the ports. It also raises the synchronizer depth to three stages, which exercises the generated chain beyond its minimum. A longer chain delays every access by one more cycle, so the bench holds the bus fields through the trailing edge and waits for the result to settle. Its reference model then shows whether a field was sampled from the wrong stage.

// File: rtl/hostif_pkg.sv
package hostif_pkg;
   localparam int BUS_W      = 8;
   localparam int BCAST_BIT  = 7;
   localparam int SEL_HI     = 6;
   localparam int SEL_LO     = 5;
   localparam int BP_CLR_BIT = 0;

   typedef enum logic [1:0] {
      SEL_CMD   = 2'b00,
      SEL_MODE  = 2'b01,
      SEL_IO    = 2'b10,
      SEL_INDEX = 2'b11
   } reg_sel_e;

   typedef struct packed {
      logic             cs_n;
      logic             rd_n;
      logic             wr_n;
      logic             cd;
      logic             axis;
      logic [BUS_W-1:0] data;
   } bus_t;

   localparam bus_t BUS_IDLE = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                                 cd: 1'b0, axis: 1'b0, data: '0};
endpackage

// File: rtl/hostif_sync.sv
module hostif_sync
   import hostif_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  bus_t bus_i,
   output logic wr_evt,
   output logic rd_evt,
   output logic rd_act,
   output bus_t wr_bus,
   output bus_t rd_bus
);
   bus_t chain [STAGES+1];

   for (genvar s = 0; s <= STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= BUS_IDLE;
            else        chain[s] <= bus_i;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= BUS_IDLE;
            else        chain[s] <= chain[s-1];
      end
   end

   bus_t cur, prv;
   assign cur = chain[STAGES-1];
   assign prv = chain[STAGES];

   // write acts on the trailing edge, with the fields seen while the strobe was low
   assign wr_evt = cur.wr_n & ~prv.wr_n & ~prv.cs_n;
   assign wr_bus = prv;
   // read acts on the leading edge
   assign rd_evt = ~cur.rd_n & prv.rd_n & ~cur.cs_n;
   assign rd_act = ~cur.rd_n & ~cur.cs_n;
   assign rd_bus = cur;
endmodule

// File: rtl/hostif_axis.sv
module hostif_axis
   import hostif_pkg::*;
#(
   parameter bit AXIS_ID = 1'b0,
   parameter int BYTES   = 3,
   parameter int CW      = 5,
   localparam int PW     = (BYTES > 1) ? $clog2(BYTES) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_evt,
   input  bus_t                   wr_bus,
   input  logic                   rd_evt,
   input  bus_t                   rd_bus,
   output logic [BYTES*BUS_W-1:0] preset_o,
   output logic [CW-1:0]          cmd_o,
   output logic [CW-1:0]          cmr_o,
   output logic [CW-1:0]          ior_o,
   output logic [CW-1:0]          idr_o,
   output logic                   cmd_stb_o,
   output logic [PW-1:0]          bp_o
);
   logic     w_mine, ctrl_hit, wdat_hit, rdat_hit;
   logic [PW-1:0] bp_next;
   reg_sel_e sel;

   assign w_mine   = (wr_bus.axis == AXIS_ID);
   assign ctrl_hit = wr_evt &  wr_bus.cd & (w_mine | wr_bus.data[BCAST_BIT]);
   assign wdat_hit = wr_evt & ~wr_bus.cd & w_mine;
   assign rdat_hit = rd_evt & ~rd_bus.cd & (rd_bus.axis == AXIS_ID);
   assign sel      = reg_sel_e'(wr_bus.data[SEL_HI:SEL_LO]);
   assign bp_next  = (bp_o == PW'(BYTES-1)) ? '0 : PW'(bp_o + 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         preset_o  <= '0;
         cmd_o     <= '0;
         cmr_o     <= '0;
         ior_o     <= '0;
         idr_o     <= '0;
         cmd_stb_o <= 1'b0;
         bp_o      <= '0;
      end else begin
         cmd_stb_o <= 1'b0;
         if (ctrl_hit) begin
            unique case (sel)
               SEL_CMD: begin
                  cmd_o     <= wr_bus.data[CW-1:0];
                  cmd_stb_o <= 1'b1;
                  if (wr_bus.data[BP_CLR_BIT]) bp_o <= '0;
               end
               SEL_MODE:  cmr_o <= wr_bus.data[CW-1:0];
               SEL_IO:    ior_o <= wr_bus.data[CW-1:0];
               SEL_INDEX: idr_o <= wr_bus.data[CW-1:0];
               default: ;
            endcase
         end
         if (wdat_hit) begin
            preset_o[bp_o*BUS_W +: BUS_W] <= wr_bus.data;
            bp_o <= bp_next;
         end
         if (rdat_hit) bp_o <= bp_next;
      end
   end
endmodule

// File: rtl/dual_axis_host_port.sv
module dual_axis_host_port
   import hostif_pkg::*;
#(
   parameter int BYTES       = 3,
   parameter int CW          = 5,
   parameter int SYNC_STAGES = 2,
   localparam int AXES       = 2,
   localparam int PW         = (BYTES > 1) ? $clog2(BYTES) : 1,
   localparam int LW         = BYTES * BUS_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_n,
   input  logic               rd_n,
   input  logic               wr_n,
   input  logic               cd_i,
   input  logic               axis_i,
   input  logic [7:0]         data_i,
   output logic [7:0]         data_o,
   output logic               data_oe,
   input  logic [AXES*LW-1:0] out_latch_i,
   input  logic [AXES*8-1:0]  flags_i,
   output logic [AXES*LW-1:0] preset_o,
   output logic [AXES*CW-1:0] cmd_o,
   output logic [AXES-1:0]    cmd_stb_o,
   output logic [AXES*CW-1:0] cmr_o,
   output logic [AXES*CW-1:0] ior_o,
   output logic [AXES*CW-1:0] idr_o
);
   if (BYTES < 1 || CW < 1 || CW > SEL_LO || BP_CLR_BIT >= CW || SYNC_STAGES < 2)
      begin : g_bad_param
      $error("dual_axis_host_port: parameter out of range");
   end

   bus_t bus_in, wr_bus, rd_bus;
   logic wr_evt, rd_evt, rd_act;
   logic [AXES*PW-1:0] bp_all;
   logic [PW-1:0]      rd_bp;
   logic [7:0]         rd_byte;

   assign bus_in = '{cs_n: cs_n, rd_n: rd_n, wr_n: wr_n,
                     cd: cd_i, axis: axis_i, data: data_i};

   hostif_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .bus_i(bus_in),
      .wr_evt(wr_evt), .rd_evt(rd_evt), .rd_act(rd_act),
      .wr_bus(wr_bus), .rd_bus(rd_bus)
   );

   for (genvar a = 0; a < AXES; a++) begin : g_axis
      hostif_axis #(.AXIS_ID(1'(a)), .BYTES(BYTES), .CW(CW)) axis_i_u (
         .clk(clk), .rst_n(rst_n),
         .wr_evt(wr_evt), .wr_bus(wr_bus),
         .rd_evt(rd_evt), .rd_bus(rd_bus),
         .preset_o(preset_o[a*LW +: LW]),
         .cmd_o(cmd_o[a*CW +: CW]),
         .cmr_o(cmr_o[a*CW +: CW]),
         .ior_o(ior_o[a*CW +: CW]),
         .idr_o(idr_o[a*CW +: CW]),
         .cmd_stb_o(cmd_stb_o[a]),
         .bp_o(bp_all[a*PW +: PW])
      );
   end

   assign rd_bp = bp_all[rd_bus.axis*PW +: PW];

   always_comb begin
      if (rd_bus.cd) rd_byte = flags_i[rd_bus.axis*8 +: 8];
      else           rd_byte = out_latch_i[(rd_bus.axis*BYTES + rd_bp)*BUS_W +: BUS_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o  <= '0;
         data_oe <= 1'b0;
      end else begin
         if (rd_evt) data_o <= rd_byte;
         data_oe <= rd_evt | (data_oe & rd_act);
      end
   end
endmodule

// File: rtl/dual_axis_host_port_chk.sv
module dual_axis_host_port_chk #(
   parameter int BYTES = 3,
   parameter int CW    = 5,
   parameter int PW    = 2,
   parameter int LW    = 24
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_evt,
   input logic            rd_evt,
   input logic            data_oe,
   input logic [2*LW-1:0] preset_o,
   input logic [2*CW-1:0] cmd_o,
   input logic [2*CW-1:0] cmr_o,
   input logic [2*CW-1:0] ior_o,
   input logic [2*CW-1:0] idr_o,
   input logic [1:0]      cmd_stb_o,
   input logic [2*PW-1:0] bp_all
);
   for (genvar a = 0; a < 2; a++) begin : g_bp
      p_bp_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
         bp_all[a*PW +: PW] <= PW'(BYTES-1));
   end

   p_cmd_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb_o != 2'b00) |=> (cmd_stb_o == 2'b00));

   p_preset_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_evt) |-> $stable(preset_o));

   p_ctrl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_evt) |-> $stable({cmd_o, cmr_o, ior_o, idr_o}));

   p_bp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_evt || rd_evt) |-> $stable(bp_all));

   p_wr_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_evt |=> !wr_evt);

   p_rd_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_evt |=> !rd_evt);

   p_oe_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_oe) |-> $past(rd_evt));
endmodule

bind dual_axis_host_port dual_axis_host_port_chk #(
   .BYTES(BYTES), .CW(CW), .PW(PW), .LW(LW)
) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .rd_evt(rd_evt),
   .data_oe(data_oe), .preset_o(preset_o), .cmd_o(cmd_o), .cmr_o(cmr_o),
   .ior_o(ior_o), .idr_o(idr_o), .cmd_stb_o(cmd_stb_o), .bp_all(bp_all)
);

// File: tb/dual_axis_host_port_tb_top.sv
module dual_axis_host_port_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int BYTES = 3;
   localparam int CW    = 5;
   localparam int SYNC  = 3;
   localparam int LW    = BYTES * 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd_i = 1'b0, axis_i = 1'b0;
   logic [7:0] data_i = '0, data_o;
   logic data_oe;
   logic [2*LW-1:0] out_latch_i = {24'h0D0E0F, 24'hA1B2C3};
   logic [15:0]     flags_i     = {8'h2A, 8'h35};
   logic [2*LW-1:0] preset_o;
   logic [2*CW-1:0] cmd_o, cmr_o, ior_o, idr_o;
   logic [1:0]      cmd_stb_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_axis_host_port #(.BYTES(BYTES), .CW(CW), .SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .cd_i(cd_i), .axis_i(axis_i), .data_i(data_i), .data_o(data_o),
      .data_oe(data_oe), .out_latch_i(out_latch_i), .flags_i(flags_i),
      .preset_o(preset_o), .cmd_o(cmd_o), .cmd_stb_o(cmd_stb_o),
      .cmr_o(cmr_o), .ior_o(ior_o), .idr_o(idr_o)
   );

   int checks = 0, errors = 0;
   bit done = 0, settled = 0;

   // behavioural reference model
   logic [LW-1:0] m_preset [2];
   logic [CW-1:0] m_cmd [2], m_cmr [2], m_ior [2], m_idr [2];
   int m_bp [2];
   int m_pulses [2];
   int seen_pulses [2];

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic verify_all(string req);
      for (int a = 0; a < 2; a++) begin
         chk(preset_o[a*LW +: LW] == m_preset[a], req, 32'(preset_o[a*LW +: LW]), 32'(m_preset[a]));
         chk(cmd_o[a*CW +: CW] == m_cmd[a], req, 32'(cmd_o[a*CW +: CW]), 32'(m_cmd[a]));
         chk(cmr_o[a*CW +: CW] == m_cmr[a], req, 32'(cmr_o[a*CW +: CW]), 32'(m_cmr[a]));
         chk(ior_o[a*CW +: CW] == m_ior[a], req, 32'(ior_o[a*CW +: CW]), 32'(m_ior[a]));
         chk(idr_o[a*CW +: CW] == m_idr[a], req, 32'(idr_o[a*CW +: CW]), 32'(m_idr[a]));
         chk(seen_pulses[a] == m_pulses[a], {req, " R8 strobe count"}, 32'(seen_pulses[a]), 32'(m_pulses[a]));
      end
      chk(data_oe == 1'b0, {req, " R12 idle oe"}, 32'(data_oe), 32'd0);
   endtask

   // compare the model on every clock while the bus is quiet
   always @(negedge clk) begin
      if (rst_n && settled && !done) begin
         checks++;
         if (preset_o != {m_preset[1], m_preset[0]} ||
             cmr_o != {m_cmr[1], m_cmr[0]} || ior_o != {m_ior[1], m_ior[0]} ||
             idr_o != {m_idr[1], m_idr[0]} || cmd_o != {m_cmd[1], m_cmd[0]}) begin
            errors++;
            $display("FAIL R2 R5 per-clock compare actual=%0h expected=%0h",
                     preset_o, {m_preset[1], m_preset[0]});
         end
      end
   end

   always @(negedge clk)
      if (rst_n)
         for (int a = 0; a < 2; a++) if (cmd_stb_o[a]) seen_pulses[a]++;

   task automatic model_write(bit cd, bit ax, logic [7:0] d);
      if (cd) begin
         for (int a = 0; a < 2; a++) begin
            if (d[7] || (a == int'(ax))) begin
               case (d[6:5])
                  2'b00: begin
                     m_cmd[a] = d[4:0];
                     m_pulses[a]++;
                     if (d[0]) m_bp[a] = 0;
                  end
                  2'b01: m_cmr[a] = d[4:0];
                  2'b10: m_ior[a] = d[4:0];
                  default: m_idr[a] = d[4:0];
               endcase
            end
         end
      end else begin
         m_preset[ax][m_bp[ax]*8 +: 8] = d;
         m_bp[ax] = (m_bp[ax] + 1) % BYTES;
      end
   endtask

   task automatic host_write(bit cd, bit ax, logic [7:0] d, bit cs_off, string req);
      @(negedge clk);
      settled = 0;
      cs_n = cs_off; cd_i = cd; axis_i = ax; data_i = d;
      repeat (2) @(negedge clk);
      wr_n = 1'b0;
      repeat (3) @(negedge clk);
      wr_n = 1'b1;
      repeat (2) @(negedge clk);
      cs_n = 1'b1;
      repeat (SYNC + 4) @(negedge clk);
      if (!cs_off) model_write(cd, ax, d);
      settled = 1;
      verify_all(req);
   endtask

   task automatic host_read(bit cd, bit ax, bit cs_off, string req);
      logic [7:0] exp;
      exp = cd ? flags_i[ax*8 +: 8] : out_latch_i[ax*LW + m_bp[ax]*8 +: 8];
      @(negedge clk);
      settled = 0;
      cs_n = cs_off; cd_i = cd; axis_i = ax;
      repeat (2) @(negedge clk);
      rd_n = 1'b0;
      repeat (SYNC + 5) @(negedge clk);
      if (cs_off) begin
         chk(data_oe == 1'b0, {req, " R10 oe"}, 32'(data_oe), 32'd0);
      end else begin
         chk(data_oe == 1'b1, {req, " R12 oe"}, 32'(data_oe), 32'd1);
         chk(data_o == exp, req, 32'(data_o), 32'(exp));
         if (!cd) m_bp[ax] = (m_bp[ax] + 1) % BYTES;
      end
      rd_n = 1'b1;
      cs_n = 1'b1;
      repeat (SYNC + 4) @(negedge clk);
      settled = 1;
      verify_all(req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int a = 0; a < 2; a++) begin
         m_preset[a] = '0; m_cmd[a] = '0; m_cmr[a] = '0; m_ior[a] = '0;
         m_idr[a] = '0; m_bp[a] = 0; m_pulses[a] = 0; seen_pulses[a] = 0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      settled = 1;
      verify_all("R1 reset");
      chk(data_o == 8'h00, "R1 reset data_o", 32'(data_o), 32'd0);

      host_write(1, 0, 8'h35, 0, "R5 mode X keeps bits 4:0");
      host_write(1, 1, 8'h7F, 0, "R5 index Y");
      host_write(1, 0, 8'hCA, 0, "R6 broadcast io");
      host_write(1, 0, 8'h01, 0, "R7 command clears X pointer");
      host_write(0, 0, 8'h11, 0, "R2 X byte0");
      host_write(0, 0, 8'h22, 0, "R2 X byte1");
      host_write(0, 0, 8'h33, 0, "R2 R11 X byte2");
      host_write(0, 0, 8'h44, 0, "R3 X wrap to byte0");
      host_write(0, 1, 8'h5A, 0, "R2 Y byte0");
      host_write(0, 0, 8'h99, 1, "R10 write with cs high ignored");
      host_write(1, 0, 8'h04, 0, "R7 command without clear");
      host_write(0, 0, 8'h77, 0, "R7 R10 pointer kept at byte1");
      host_write(1, 1, 8'h81, 0, "R6 R7 R8 broadcast clear");

      host_read(0, 0, 0, "R4 R11 X read byte0");
      host_read(0, 0, 0, "R4 X read byte1");
      host_read(0, 0, 0, "R4 X read byte2");
      host_read(0, 0, 0, "R3 R4 X read wraps");
      host_read(1, 0, 0, "R9 X flags");
      host_read(1, 1, 0, "R9 Y flags");
      host_read(0, 0, 0, "R9 pointer unmoved by flag read");
      host_read(0, 1, 0, "R4 Y read byte0");
      host_read(0, 1, 1, "R10 read with cs high");
      host_read(0, 1, 0, "R10 Y pointer unmoved by ignored read");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule